// File: doc/BRIEF.md
# DMA Channel Address Generator

This block produces the read-side and write-side addresses for a single DMA channel. The channel is organised as nested loops. An inner (minor) loop moves a programmed number of bytes, one beat at a time. An outer (major) loop repeats the inner loop a programmed number of times. The data mover reports each finished beat on `beat_done`. The block then advances both addresses and its loop counters, and it flags the end of each inner loop and of the whole run.

Each side has its own settings: start address, encoded beat width, signed per-beat stride, wrap window and signed end-of-run correction. A non-zero wrap window `m` fixes every address bit at position `m` and above, so the address circles inside an aligned buffer of 2^m bytes. This suits peripheral FIFOs and ring buffers. When the last beat of the last inner loop is done, the end-of-run correction is added, usually to bring the address back to where it started.

A pulse on `start` while the channel is idle captures the whole configuration and begins a run. The configuration inputs are free to change during the run.

Top module: `dma_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it rises, `src_addr`, `dst_addr`, `busy`, `minor_end`, `major_end` and `xfer_size` are all zero.
- R2: A `start` pulse while `busy` is low has these effects one cycle later: `busy` is 1, and `src_addr`/`dst_addr` equal the configured start addresses.
- R3: Each `beat_done` while `busy` adds that side's signed 32-bit stride to its address, in two's complement, when its wrap field is 0. Without `beat_done` the addresses hold.
- R4: With a wrap field m in 1..31, a beat replaces only the low m bits of the address with the low m bits of (address + stride). The bits above stay as they were.
- R5: While busy, `xfer_size` holds the larger of the two encoded widths (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes). A beat moves that many bytes.
- R6: `minor_end` is high for exactly the cycle after the beat that brings the bytes of the current inner loop to the configured count. The count then restarts for the next inner loop.
- R7: On the last beat of the last inner loop, each side's address becomes (wrapped address + stride) + end-of-run correction. In the following cycle `major_end` and `minor_end` are both high and `busy` is low.
- R8: `beat_done` while `busy` is low changes nothing. `start` while `busy` is high is ignored.
- R9: A fresh `start` after a run completes repeats the configured number of inner loops, because the iteration counter reloads at the end of the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run (honoured only while idle) |
| beat_done | input | 1 | One beat finished by the data mover |
| cfg_src_addr | input | 32 | Read-side start address |
| cfg_src_size | input | 2 | Read-side encoded width |
| cfg_src_stride | input | 32 | Read-side signed per-beat offset |
| cfg_src_wrap | input | 5 | Read-side wrap window (0 = none) |
| cfg_src_fix | input | 32 | Read-side signed end-of-run correction |
| cfg_dst_addr | input | 32 | Write-side start address |
| cfg_dst_size | input | 2 | Write-side encoded width |
| cfg_dst_stride | input | 32 | Write-side signed per-beat offset |
| cfg_dst_wrap | input | 5 | Write-side wrap window (0 = none) |
| cfg_dst_fix | input | 32 | Write-side signed end-of-run correction |
| cfg_loop_bytes | input | 16 | Bytes per inner loop |
| cfg_loop_count | input | 16 | Inner loops per run |
| src_addr | output | 32 | Current read-side address |
| dst_addr | output | 32 | Current write-side address |
| xfer_size | output | 2 | Encoded beat width of the run |
| busy | output | 1 | Run in progress |
| minor_end | output | 1 | Inner loop just completed |
| major_end | output | 1 | Whole run just completed |

## Verification
The assertions assume three things about the inputs. The byte count is a non-zero multiple of the beat width. The loop count is at least one. The encoded widths are never 3. With these in place, every run ends with `major_end`, and the wrap check only has to compare the bits above the captured window. The stimulus starts each run from a bench-held configuration that meets these rules. It mixes idle gaps, back-to-back beats, stray `beat_done` pulses while idle and `start` pulses during a run. A behavioural model in the bench predicts every output on every cycle.

// File: rtl/dma_ag_pkg.sv
// Package: shared widths and address helpers for the DMA address generator.
// Assumes wrap values stay below ADDR_W.
package dma_ag_pkg;
    localparam int ADDR_W = 32;
    localparam int WRAP_W = 5;
    localparam int SIZE_W = 2;

    // Byte count of one beat for an encoded width (0,1,2 -> 1,2,4).
    function automatic logic [3:0] beat_bytes(input logic [SIZE_W-1:0] enc);
        beat_bytes = 4'd1 << enc;
    endfunction

    // Merge low bits of the sum into the address, keeping bits at and above the window.
    function automatic logic [ADDR_W-1:0] wrap_add(
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] sum,
        input logic [WRAP_W-1:0] win
    );
        logic [ADDR_W-1:0] keep_low;
        keep_low = (win == '0) ? '1 : ((ADDR_W'(1) << win) - ADDR_W'(1));
        wrap_add = (base & ~keep_low) | (sum & keep_low);
    endfunction
endpackage

// File: rtl/dma_ag_side.sv
// Module: one address lane (read or write side).
// Captures its settings on load, advances by stride (with optional wrap) on step,
// and adds the end-of-run correction on the final beat.
// Assumes load and step are never high together.
module dma_ag_side
    import dma_ag_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int WW = WRAP_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          final_beat,
    input  logic [AW-1:0] cfg_addr,
    input  logic [AW-1:0] cfg_stride,
    input  logic [WW-1:0] cfg_wrap,
    input  logic [AW-1:0] cfg_fix,
    output logic [AW-1:0] addr_o,
    output logic [WW-1:0] wrap_o
);
    logic [AW-1:0] addr_q, stride_q, fix_q, addr_nxt;
    logic [WW-1:0] wrap_q;

    // Next address: stride inside the wrap window, then the optional correction.
    always_comb begin
        addr_nxt = wrap_add(addr_q, addr_q + stride_q, wrap_q);
        if (final_beat) begin
            addr_nxt = addr_nxt + fix_q;
        end
    end

    // Capture settings at load and update the address on each beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            stride_q <= '0;
            fix_q    <= '0;
            wrap_q   <= '0;
        end else if (load) begin
            addr_q   <= cfg_addr;
            stride_q <= cfg_stride;
            fix_q    <= cfg_fix;
            wrap_q   <= cfg_wrap;
        end else if (step) begin
            addr_q   <= addr_nxt;
        end
    end

    assign addr_o = addr_q;
    assign wrap_o = wrap_q;
endmodule

// File: rtl/dma_ag_loopctl.sv
// Module: inner/outer loop counters and channel state.
// Counts bytes per inner loop and inner loops per run, and produces the
// load/step/final strobes for the address lanes.
// Assumes byte count is a non-zero multiple of the beat width and loop count >= 1.
module dma_ag_loopctl
    import dma_ag_pkg::*;
#(
    parameter int NBW = 16,
    parameter int ITW = 16,
    parameter int SW  = SIZE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           beat_done,
    input  logic [SW-1:0]  cfg_src_size,
    input  logic [SW-1:0]  cfg_dst_size,
    input  logic [NBW-1:0] cfg_loop_bytes,
    input  logic [ITW-1:0] cfg_loop_count,
    output logic           load,
    output logic           step,
    output logic           final_beat,
    output logic           busy,
    output logic           minor_end,
    output logic           major_end,
    output logic [SW-1:0]  xfer_size
);
    logic           busy_q, minor_q, major_q;
    logic [SW-1:0]  size_q, size_pick;
    logic [NBW-1:0] rem_q, nbytes_q, step_bytes;
    logic [ITW-1:0] iter_q, iter_init_q;
    logic           last_minor;

    // Pick the wider of the two encoded widths for the run.
    assign size_pick  = (cfg_src_size > cfg_dst_size) ? cfg_src_size : cfg_dst_size;
    // Strobes seen by the lanes.
    assign step_bytes = NBW'(beat_bytes(size_q));
    assign load       = start && !busy_q;
    assign step       = beat_done && busy_q;
    assign last_minor = rem_q <= step_bytes;
    assign final_beat = step && last_minor && (iter_q == ITW'(1));

    // Loop counters, run state and registered end-of-loop pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            minor_q     <= 1'b0;
            major_q     <= 1'b0;
            size_q      <= '0;
            rem_q       <= '0;
            nbytes_q    <= '0;
            iter_q      <= '0;
            iter_init_q <= '0;
        end else begin
            minor_q <= 1'b0;
            major_q <= 1'b0;
            if (load) begin
                busy_q      <= 1'b1;
                size_q      <= size_pick;
                rem_q       <= cfg_loop_bytes;
                nbytes_q    <= cfg_loop_bytes;
                iter_q      <= cfg_loop_count;
                iter_init_q <= cfg_loop_count;
            end else if (step) begin
                if (last_minor) begin
                    minor_q <= 1'b1;
                    rem_q   <= nbytes_q;
                    if (final_beat) begin
                        major_q <= 1'b1;
                        busy_q  <= 1'b0;
                        iter_q  <= iter_init_q;
                    end else begin
                        iter_q  <= iter_q - ITW'(1);
                    end
                end else begin
                    rem_q <= rem_q - step_bytes;
                end
            end
        end
    end

    assign busy      = busy_q;
    assign minor_end = minor_q;
    assign major_end = major_q;
    assign xfer_size = size_q;
endmodule

// File: rtl/dma_addr_gen.sv
// Module: DMA channel address generator (top).
// Joins the loop controller with one address lane per side, chosen by a generate loop.
// Assumes configuration meets the rules in the brief when start is pulsed.
module dma_addr_gen
    import dma_ag_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int WW  = WRAP_W,
    parameter int SW  = SIZE_W,
    parameter int NBW = 16,
    parameter int ITW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           beat_done,
    input  logic [AW-1:0]  cfg_src_addr,
    input  logic [SW-1:0]  cfg_src_size,
    input  logic [AW-1:0]  cfg_src_stride,
    input  logic [WW-1:0]  cfg_src_wrap,
    input  logic [AW-1:0]  cfg_src_fix,
    input  logic [AW-1:0]  cfg_dst_addr,
    input  logic [SW-1:0]  cfg_dst_size,
    input  logic [AW-1:0]  cfg_dst_stride,
    input  logic [WW-1:0]  cfg_dst_wrap,
    input  logic [AW-1:0]  cfg_dst_fix,
    input  logic [NBW-1:0] cfg_loop_bytes,
    input  logic [ITW-1:0] cfg_loop_count,
    output logic [AW-1:0]  src_addr,
    output logic [AW-1:0]  dst_addr,
    output logic [SW-1:0]  xfer_size,
    output logic           busy,
    output logic           minor_end,
    output logic           major_end
);
    localparam int LANES = 2;

    logic load, step, final_beat;
    logic [AW-1:0] lane_addr   [LANES];
    logic [AW-1:0] lane_stride [LANES];
    logic [AW-1:0] lane_fix    [LANES];
    logic [AW-1:0] lane_out    [LANES];
    logic [WW-1:0] lane_wrap   [LANES];
    logic [WW-1:0] lane_wrap_q [LANES];
    logic [WW-1:0] src_wrap_q, dst_wrap_q;

    // Gather per-side settings into lane arrays (0 = read side, 1 = write side).
    always_comb begin
        lane_addr[0]   = cfg_src_addr;
        lane_stride[0] = cfg_src_stride;
        lane_fix[0]    = cfg_src_fix;
        lane_wrap[0]   = cfg_src_wrap;
        lane_addr[1]   = cfg_dst_addr;
        lane_stride[1] = cfg_dst_stride;
        lane_fix[1]    = cfg_dst_fix;
        lane_wrap[1]   = cfg_dst_wrap;
    end

    dma_ag_loopctl #(.NBW(NBW), .ITW(ITW), .SW(SW)) u_loop (
        .clk(clk), .rst_n(rst_n), .start(start), .beat_done(beat_done),
        .cfg_src_size(cfg_src_size), .cfg_dst_size(cfg_dst_size),
        .cfg_loop_bytes(cfg_loop_bytes), .cfg_loop_count(cfg_loop_count),
        .load(load), .step(step), .final_beat(final_beat), .busy(busy),
        .minor_end(minor_end), .major_end(major_end), .xfer_size(xfer_size)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dma_ag_side #(.AW(AW), .WW(WW)) u_side (
            .clk(clk), .rst_n(rst_n), .load(load), .step(step),
            .final_beat(final_beat), .cfg_addr(lane_addr[g]),
            .cfg_stride(lane_stride[g]), .cfg_wrap(lane_wrap[g]),
            .cfg_fix(lane_fix[g]), .addr_o(lane_out[g]), .wrap_o(lane_wrap_q[g])
        );
    end

    assign src_addr   = lane_out[0];
    assign dst_addr   = lane_out[1];
    assign src_wrap_q = lane_wrap_q[0];
    assign dst_wrap_q = lane_wrap_q[1];
endmodule

// File: rtl/dma_addr_gen_chk.sv
// Module: assertion checker for dma_addr_gen, attached by bind.
// Assumes legal configuration at start (see brief).
module dma_addr_gen_chk #(
    parameter int AW = 32,
    parameter int WW = 5,
    parameter int SW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          beat_done,
    input logic          busy,
    input logic          minor_end,
    input logic          major_end,
    input logic [AW-1:0] src_addr,
    input logic [AW-1:0] dst_addr,
    input logic [AW-1:0] cfg_src_addr,
    input logic [AW-1:0] cfg_dst_addr,
    input logic [SW-1:0] xfer_size,
    input logic [WW-1:0] src_wrap_q,
    input logic [WW-1:0] dst_wrap_q
);
    // R2: idle start loads start addresses and raises busy.
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && src_addr == $past(cfg_src_addr)
                              && dst_addr == $past(cfg_dst_addr)));
    // R3: without a beat, a running channel holds its addresses.
    p_hold_nobeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !beat_done) |=> ($stable(src_addr) && $stable(dst_addr)));
    // R4: bits at and above the wrap window stay put on a non-final beat.
    p_wrap_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && beat_done && src_wrap_q != '0) |=>
        (major_end || ((src_addr >> src_wrap_q) == ($past(src_addr) >> src_wrap_q))));
    p_wrap_upper_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && beat_done && dst_wrap_q != '0) |=>
        (major_end || ((dst_addr >> dst_wrap_q) == ($past(dst_addr) >> dst_wrap_q))));
    // R5: the encoded width is never the reserved value.
    p_size_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_size != SW'(3));
    // R7: end of run coincides with end of inner loop and an idle channel.
    p_major_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        major_end |-> (minor_end && !busy));
    // R8: idle without start keeps both addresses.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(src_addr) && $stable(dst_addr) && !busy));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.AW(AW), .WW(WW), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .beat_done(beat_done),
    .busy(busy), .minor_end(minor_end), .major_end(major_end),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .xfer_size(xfer_size), .src_wrap_q(src_wrap_q), .dst_wrap_q(dst_wrap_q)
);

// File: tb/dma_addr_gen_tb.sv
// Bench: behavioural model of the channel, compared with the design after every clock.
module dma_addr_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        beat_done = 1'b0;
    logic [31:0] c_saddr = '0, c_sstride = '0, c_sfix = '0;
    logic [31:0] c_daddr = '0, c_dstride = '0, c_dfix = '0;
    logic [1:0]  c_ssize = '0, c_dsize = '0;
    logic [4:0]  c_swrap = '0, c_dwrap = '0;
    logic [15:0] c_nbytes = '0, c_iter = '0;
    logic [31:0] src_addr, dst_addr;
    logic [1:0]  xfer_size;
    logic        busy, minor_end, major_end;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // Model state
    logic [31:0] m_src = '0, m_dst = '0, m_sst, m_dst_st, m_sfx, m_dfx;
    int m_sw, m_dw, m_size = 0, m_rem, m_nb, m_iter, m_it0;
    bit m_busy = 0, m_minor = 0, m_major = 0;
    int minor_seen;
    string addr_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .beat_done(beat_done),
        .cfg_src_addr(c_saddr), .cfg_src_size(c_ssize), .cfg_src_stride(c_sstride),
        .cfg_src_wrap(c_swrap), .cfg_src_fix(c_sfix),
        .cfg_dst_addr(c_daddr), .cfg_dst_size(c_dsize), .cfg_dst_stride(c_dstride),
        .cfg_dst_wrap(c_dwrap), .cfg_dst_fix(c_dfix),
        .cfg_loop_bytes(c_nbytes), .cfg_loop_count(c_iter),
        .src_addr(src_addr), .dst_addr(dst_addr), .xfer_size(xfer_size),
        .busy(busy), .minor_end(minor_end), .major_end(major_end)
    );

    function automatic logic [31:0] circ(logic [31:0] a, logic [31:0] s, int w);
        longint span, ua, us;
        if (w == 0) return s;
        span = longint'(1) << w;
        ua = longint'({32'b0, a});
        us = longint'({32'b0, s});
        return 32'((ua - (ua % span)) + (us % span));
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(addr_req, "src_addr", src_addr, m_src);
        chk(addr_req, "dst_addr", dst_addr, m_dst);
        chk("R2", "busy", busy, m_busy);
        chk("R6", "minor_end", minor_end, m_minor);
        chk("R7", "major_end", major_end, m_major);
        chk("R5", "xfer_size", xfer_size, m_size);
    endtask

    // One clock: drive inputs, advance the model, compare after the edge.
    task automatic tick(input bit st, input bit bt);
        bit lastm, fin;
        int bb;
        start = st;
        beat_done = bt;
        m_minor = 0;
        m_major = 0;
        if (st && !m_busy) begin
            m_src = c_saddr; m_dst = c_daddr;
            m_sst = c_sstride; m_dst_st = c_dstride;
            m_sfx = c_sfix; m_dfx = c_dfix;
            m_sw = c_swrap; m_dw = c_dwrap;
            m_size = (c_ssize > c_dsize) ? c_ssize : c_dsize;
            m_nb = c_nbytes; m_rem = c_nbytes;
            m_iter = c_iter; m_it0 = c_iter;
            m_busy = 1;
        end else if (bt && m_busy) begin
            bb = 1 << m_size;
            lastm = (m_rem <= bb);
            fin = lastm && (m_iter == 1);
            m_src = circ(m_src, m_src + m_sst, m_sw) + (fin ? m_sfx : 32'd0);
            m_dst = circ(m_dst, m_dst + m_dst_st, m_dw) + (fin ? m_dfx : 32'd0);
            if (lastm) begin
                m_minor = 1;
                minor_seen++;
                m_rem = m_nb;
                if (fin) begin
                    m_major = 1;
                    m_busy = 0;
                    m_iter = m_it0;
                end else begin
                    m_iter--;
                end
            end else begin
                m_rem -= bb;
            end
        end
        @(posedge clk);
        @(negedge clk);
        start = 0;
        beat_done = 0;
        compare_all();
    endtask

    // Start a run and feed beats (with some gaps) until it completes.
    task automatic run(input int gap_every, input bit poke_start);
        int i = 0;
        minor_seen = 0;
        tick(1, 0);
        while (m_busy && i < 2000) begin
            if (gap_every > 0 && (i % gap_every) == 1) tick(0, 0);
            if (poke_start && i == 2) tick(1, 1);   // R8: start during run ignored
            else tick(0, 1);
            i++;
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        addr_req = "R1";
        compare_all();
        rst_n = 1'b1;
        @(negedge clk);
        compare_all();

        // R8: beats while idle do nothing
        addr_req = "R8";
        c_saddr = 32'h0000_1000;
        tick(0, 1);
        tick(0, 1);

        // R3/R7: plain strides, 4-byte beats, 2 inner loops of 8 bytes
        addr_req = "R3";
        c_saddr = 32'h0000_1000; c_ssize = 2; c_sstride = 32'd4; c_swrap = 0; c_sfix = -32'sd16;
        c_daddr = 32'h0000_2000; c_dsize = 0; c_dstride = 32'd1; c_dwrap = 0; c_dfix = 32'd100;
        c_nbytes = 16'd8; c_iter = 16'd2;
        run(3, 1);
        chk("R9", "inner loops first run", minor_seen, 2);
        addr_req = "R7";
        tick(0, 0);

        // R9: same configuration again repeats the loop count
        addr_req = "R9";
        run(0, 0);
        chk("R9", "inner loops second run", minor_seen, 2);

        // R4: wrapping read side in an 8-byte window, negative write stride, 2-byte beats
        addr_req = "R4";
        c_saddr = 32'h0000_3004; c_ssize = 1; c_sstride = 32'd2; c_swrap = 5'd3; c_sfix = 32'd0;
        c_daddr = 32'h0000_0002; c_dsize = 0; c_dstride = -32'sd2; c_dwrap = 0; c_dfix = 32'd10;
        c_nbytes = 16'd4; c_iter = 16'd5;
        run(4, 0);
        chk("R6", "inner loops wrap run", minor_seen, 5);

        // R4/R5: wrap on write side, 1-byte beats both sides, one inner loop
        addr_req = "R4";
        c_saddr = 32'hFFFF_FFFE; c_ssize = 0; c_sstride = 32'd1; c_swrap = 0; c_sfix = 32'd5;
        c_daddr = 32'h0000_40FD; c_dsize = 0; c_dstride = 32'd1; c_dwrap = 5'd4; c_dfix = -32'sd1;
        c_nbytes = 16'd6; c_iter = 16'd1;
        run(2, 1);
        tick(0, 1);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule